// File: doc/BRIEF.md
# Noise-Shaped Phase Direct Digital Synthesizer

This core generates a sampled sine wave whose frequency is set by a tuning word. A 16-bit phase register steps by the tuning word on every enabled clock and wraps around naturally. The top twelve bits of that phase are not simply cut down to a table address. A fourth-order error-feedback loop requantizes them to eight bits instead. The four bits that are dropped are fed back with the weights of (1 - z^-1)^4, which pushes the truncation error toward high frequencies and away from discrete spurs. The eight-bit address reads a 256-entry full-cycle sine table. That table is one sixteenth of the size an unshaped twelve-bit phase would need.

One sample is produced per enabled clock. The accumulate, shape and lookup steps are separate register stages, and a valid flag travels alongside the data. The table is computed at elaboration time from a constant function, so the block needs no external file. A synchronous reset clears the phase, the loop memory and the output.

Top module: `nsdds_core`

## Requirements
- R1: On a clock with the enable high, the 16-bit phase register becomes (phase + tuning word) mod 65536.
- R2: The word fed to the shaper is bits [15:4] of the phase register, taken after its update.
- R3: The shaper forms s = P + 4*e1 - 6*e2 + 4*e3 - e4. Here P is the 12-bit phase word and e1..e4 are its four previous error values, newest first. The new error is s mod 16 and the table address is floor(s/16) mod 256.
- R4: The output is the table entry round(2047*sin(2*pi*a/256)) for address a, as a 12-bit two's complement value.
- R5: On a clock with the enable low, the phase register and the shaper memory hold their values, no sample is produced, and the following samples continue the sequence without a gap.
- R6: A sample whose phase update happens at clock edge k is on the output after edge k+2, with the valid flag high. The valid flag is high exactly at those times.
- R7: While reset is high at a clock edge, the phase, all four error values, the address, the output and the valid flag are cleared.
- R8: The shaped address never differs from the top eight phase bits by more than -7..+8 steps (mod 256). With a tuning word of zero, the output keeps following the R3 sequence around the held phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the phase and issue a sample this clock |
| ftw_i | input | 16 | Frequency tuning word, unsigned |
| amp_o | output | 12 | Signed sine amplitude sample |
| valid_o | output | 1 | amp_o holds a new sample |

## Verification
Four properties run on every cycle. The phase holds while the enable is low. The shaped address stays within its bounded distance from the coarse phase. The output never reaches the most negative code. The valid flag lags the enable by three clocks and clears after reset. Only the bench scenarios can show that the exact sample sequence matches the shaping recurrence and the rounded sine values. This covers several tuning words, heavy wraparound, a zero word, an enable that toggles between samples, and a reset in the middle of a run that restarts the sequence from a clean loop state.

// File: rtl/nsdds_pkg.sv
package nsdds_pkg;

   localparam real TWO_PI  = 6.283185307179586;
   localparam int  NS_TAPS = 4;

   // Feedback weights of the (1 - z^-1)^4 error loop, newest tap first.
   function automatic int ntf_weight(input int tap);
      case (tap)
         0:       return 4;
         1:       return -6;
         2:       return 4;
         default: return -1;
      endcase
   endfunction

   // Rounded full-scale sine code for table index idx out of depth entries.
   function automatic int sine_code(input int idx, input int depth, input int amp_w);
      real peak;
      real s;
      peak = real'((1 << (amp_w - 1)) - 1);
      s    = peak * $sin(TWO_PI * real'(idx) / real'(depth));
      if (s >= 0.0) return $rtoi(s + 0.5);
      else          return -$rtoi(0.5 - s);
   endfunction

endpackage

// File: rtl/nsdds_phase_acc.sv
module nsdds_phase_acc #(
   parameter int ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_i,
   input  logic [ACC_W-1:0] ftw_i,
   output logic [ACC_W-1:0] phase_o,
   output logic             vld_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_o <= '0;
         vld_o   <= 1'b0;
      end else begin
         vld_o <= en_i;
         if (en_i) phase_o <= phase_o + ftw_i;
      end
   end

   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst) !en_i |=> $stable(phase_o)); // R5

endmodule

// File: rtl/nsdds_phase_shaper.sv
module nsdds_phase_shaper #(
   parameter int PHASE_W     = 12,
   parameter int ADDR_W      = 8,
   parameter bit NOISE_SHAPE = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PHASE_W-1:0] phase_i,
   input  logic               vld_i,
   output logic [ADDR_W-1:0]  addr_o,
   output logic               vld_o
);
   import nsdds_pkg::*;

   localparam int DROP = PHASE_W - ADDR_W;

   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

   generate
      if (NOISE_SHAPE) begin : g_shaped
         logic [DROP-1:0]    err_q [NS_TAPS];
         logic [PHASE_W-1:0] sum;

         // Modular sum: only the low PHASE_W bits survive the wrap, so no guard bits.
         always_comb begin
            sum = phase_i;
            for (int t = 0; t < NS_TAPS; t++)
               sum = sum + PHASE_W'(ntf_weight(t)) * PHASE_W'(err_q[t]);
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               addr_o <= '0;
               for (int t = 0; t < NS_TAPS; t++) err_q[t] <= '0;
            end else if (vld_i) begin
               addr_o   <= sum[PHASE_W-1:DROP];
               err_q[0] <= sum[DROP-1:0];
               for (int t = 1; t < NS_TAPS; t++) err_q[t] <= err_q[t-1];
            end
         end

         AST_SHAPE_BOUND: assert property (@(posedge clk) disable iff (rst)
            vld_i |=> ($signed(ADDR_W'(addr_o - $past(phase_i[PHASE_W-1:DROP]))) <= 8 &&
                       $signed(ADDR_W'(addr_o - $past(phase_i[PHASE_W-1:DROP]))) >= -7)); // R8
      end else begin : g_trunc
         always_ff @(posedge clk) begin
            if (rst)        addr_o <= '0;
            else if (vld_i) addr_o <= phase_i[PHASE_W-1:DROP];
         end
      end
   endgenerate

endmodule

// File: rtl/nsdds_sine_rom.sv
module nsdds_sine_rom #(
   parameter int ADDR_W = 8,
   parameter int AMP_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    vld_i,
   output logic signed [AMP_W-1:0] amp_o,
   output logic                    vld_o
);
   import nsdds_pkg::*;

   localparam int DEPTH = 1 << ADDR_W;
   localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

   logic signed [AMP_W-1:0] table_w [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_tab
      assign table_w[k] = AMP_W'(sine_code(k, DEPTH, AMP_W));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         amp_o <= '0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) amp_o <= table_w[addr_i];
      end
   end

   AST_AMP_RANGE: assert property (@(posedge clk) disable iff (rst) vld_o |-> amp_o != MOST_NEG); // R4

endmodule

// File: rtl/nsdds_core.sv
module nsdds_core #(
   parameter int ACC_W       = 16,
   parameter int PHASE_W     = 12,
   parameter int ADDR_W      = 8,
   parameter int AMP_W       = 12,
   parameter bit NOISE_SHAPE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en_i,
   input  logic [ACC_W-1:0]        ftw_i,
   output logic signed [AMP_W-1:0] amp_o,
   output logic                    valid_o
);

   generate
      if (PHASE_W > ACC_W)  begin : g_chk_phase $error("phase word wider than accumulator"); end
      if (ADDR_W >= PHASE_W) begin : g_chk_addr $error("address must be narrower than phase word"); end
      if (ADDR_W > 12)      begin : g_chk_depth $error("sine table too deep"); end
      if (AMP_W < 4 || AMP_W > 24) begin : g_chk_amp $error("amplitude width out of range"); end
   endgenerate

   logic [ACC_W-1:0]  phase_q;
   logic              vld_acc;
   logic [ADDR_W-1:0] addr_q;
   logic              vld_shp;

   nsdds_phase_acc #(.ACC_W(ACC_W)) i_acc (
      .clk(clk), .rst(rst), .en_i(en_i), .ftw_i(ftw_i),
      .phase_o(phase_q), .vld_o(vld_acc)
   );

   nsdds_phase_shaper #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .NOISE_SHAPE(NOISE_SHAPE)) i_shaper (
      .clk(clk), .rst(rst), .phase_i(phase_q[ACC_W-1 -: PHASE_W]), .vld_i(vld_acc),
      .addr_o(addr_q), .vld_o(vld_shp)
   );

   nsdds_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) i_rom (
      .clk(clk), .rst(rst), .addr_i(addr_q), .vld_i(vld_shp),
      .amp_o(amp_o), .vld_o(valid_o)
   );

   if (ACC_W > PHASE_W) begin : g_low_bits
      logic unused_low;
      assign unused_low = ^phase_q[ACC_W-PHASE_W-1:0];
   end

   AST_VALID_LAG:  assert property (@(posedge clk) disable iff (rst) valid_o |-> $past(en_i, 3)); // R6
   AST_RST_CLEARS: assert property (@(posedge clk) $past(rst) |-> (!valid_o && amp_o == '0));   // R7

endmodule

// File: tb/test_nsdds_core.sv
`timescale 1ns/1ps
module test_nsdds_core;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               en  = 1'b0;
   logic [15:0]        ftw = '0;
   logic signed [11:0] amp;
   logic               valid;

   always #4 clk = ~clk;

   nsdds_core i_nsdds_core (
      .clk(clk), .rst(rst), .en_i(en), .ftw_i(ftw), .amp_o(amp), .valid_o(valid)
   );

   int    n_checks = 0;
   int    n_fails  = 0;
   string cur_tag  = "R1";

   // reference model state
   int m_acc = 0;
   int m_err [4] = '{0, 0, 0, 0};
   int exp_q [$];
   logic [2:0] en_hist = '0;

   function automatic int sine_ref(input int a);
      real s;
      s = 2047.0 * $sin(2.0 * 3.141592653589793 * real'(a) / 256.0);
      if (s >= 0.0) return $rtoi(s + 0.5);
      return -$rtoi(0.5 - s);
   endfunction

   task automatic check(input string tag, input int act, input int expv);
      n_checks++;
      if (act != expv) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
      end
   endtask

   // driver: applies one clock of stimulus and pushes the expected sample
   task automatic drive(input bit e, input logic [15:0] f);
      int p, s, a;
      @(negedge clk);
      en  = e;
      ftw = f;
      if (e) begin
         m_acc = (m_acc + int'(f)) & 16'hFFFF;            // R1
         p = m_acc >> 4;                                  // R2
         s = p + 4*m_err[0] - 6*m_err[1] + 4*m_err[2] - m_err[3]; // R3
         a = (s >>> 4) & 255;
         m_err[3] = m_err[2]; m_err[2] = m_err[1]; m_err[1] = m_err[0];
         m_err[0] = s & 15;
         exp_q.push_back(sine_ref(a));                    // R4
      end
   endtask

   always @(posedge clk) begin
      if (rst) en_hist <= '0;
      else     en_hist <= {en_hist[1:0], en};
   end

   // monitor: compares valid timing and pops samples
   always @(negedge clk) begin
      if (!rst) begin
         check("R6 valid timing", int'(valid), int'(en_hist[2]));
         if (valid) begin
            if (exp_q.size() == 0) check({"R3 R4 unexpected sample ", cur_tag}, int'(amp), 99999);
            else check({"R3 R4 sample ", cur_tag}, int'(amp), exp_q.pop_front());
         end
      end
   end

   task automatic do_reset();
      repeat (4) drive(1'b0, ftw);
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R7 valid in reset", int'(valid), 0);
      check("R7 amp in reset", int'(amp), 0);
      rst   = 1'b0;
      m_acc = 0;
      m_err = '{0, 0, 0, 0};
      exp_q.delete();
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R7 valid after reset", int'(valid), 0);
      check("R7 amp after reset", int'(amp), 0);
      rst = 1'b0;

      cur_tag = "R1 R2";
      for (int i = 0; i < 300; i++) drive(1'b1, 16'h0123);

      cur_tag = "R1 wrap";
      for (int i = 0; i < 200; i++) drive(1'b1, 16'hFFF1);
      for (int i = 0; i < 100; i++) drive(1'b1, 16'h8000);

      cur_tag = "R8 zero word";
      for (int i = 0; i < 80; i++) drive(1'b1, 16'h0000);

      cur_tag = "R5 gaps";
      for (int i = 0; i < 200; i++) drive((i % 3) != 1, 16'h0A55);
      for (int i = 0; i < 40; i++)  drive(1'b0, 16'h7777);
      for (int i = 0; i < 60; i++)  drive(1'b1, 16'h0A55);

      cur_tag = "R7 restart";
      do_reset();
      for (int i = 0; i < 150; i++) drive(1'b1, 16'h0123);
      for (int i = 0; i < 150; i++) drive(1'b1, 16'h3FD7);

      repeat (5) drive(1'b0, 16'h0000);
      check("R5 queue drained", exp_q.size(), 0);
      report();
   end

endmodule